// File: doc/BRIEF.md
# Seed-Selectable Payload Scrambler

This block whitens the payload bits of a serial data frame with an additive keystream taken from a 16-bit linear feedback shift register. One block serves both directions. On transmit it scrambles the data. On receive, loaded with the same seed, it descrambles the data. Header bits pass through untouched. A frame-start pulse begins a header. A header-done pulse reloads the shift register with the selected seed, and every valid bit after that pulse is combined with the keystream.

A 2-bit mode code selects the seed: a fixed all-ones default, one of two programmable seed registers, or no scrambling at all. The mode and the selected seed are captured when the header-done pulse arrives. Later register writes or mode changes therefore take effect only from the next frame.

Top module: `seed_scrambler`

## Requirements
- R1: While reset is asserted, and until the first valid bit has been registered after reset, out_valid and out_bit are 0. The reset value of both seed registers is 0x0000.
- R2: out_valid equals in_valid delayed by one clock. out_bit is produced one clock after its input bit, and is 0 in any cycle where out_valid is 0.
- R3: These valid bits leave unchanged: bits in the frame_start cycle, bits after it up to the hdr_done cycle, and bits in the hdr_done cycle itself.
- R4: Every valid bit after the hdr_done cycle leaves as in_bit XOR s[15], where s is the 16-bit state. The state then shifts left once with new s[0] = s[15]^s[13]^s[12]^s[10]. Cycles without in_valid leave the state unchanged.
- R5: mode_sel encoding: 0 picks the fixed seed 0xFFFF, 1 picks seed register 1, 2 picks seed register 2, and 3 passes payload bits through unchanged with the same latency.
- R6: A cycle with seed_wr=1 loads seed_wr_data into seed register 1 when seed_wr_idx=0, or into seed register 2 when seed_wr_idx=1. The next frame that selects that register uses the new value as its seed.
- R7: In the hdr_done cycle the state loads the seed picked by mode_sel and the mode is captured. Seed writes and mode_sel changes after that cycle do not alter the current frame's output.
- R8: A selected seed of 0x0000 gives an all-zero keystream, so payload bits leave unchanged.
- R9: Two blocks in series with the same mode and seeds, the second fed the first's output and control pulses one cycle later, return the original bit sequence two cycles after input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that begins a frame header |
| hdr_done | input | 1 | Pulse marking the last header cycle; reseeds the state |
| mode_sel | input | 2 | Seed/mode select: 0 fixed, 1 seed 1, 2 seed 2, 3 off |
| seed_wr | input | 1 | Seed register write strobe |
| seed_wr_idx | input | 1 | Seed register index: 0 seed 1, 1 seed 2 |
| seed_wr_data | input | 16 | Seed value to write |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit strobe |
| out_bit | output | 1 | Serial output bit |

## Verification
Every output bit is due exactly one clock after the cycle that presented it. A seed or mode captured at hdr_done governs the first payload bit in the following cycle. The round-trip result from the chained second instance is due two clocks after the original bit. The bench drives each cycle on the falling edge and samples just after the next rising edge. It compares against a keystream it computes from the polynomial, and it holds the previous cycle's input in order to check the chained instance one cycle later.

// File: rtl/seed_scrambler.sv
module seed_scrambler #(
  parameter int W = 16,
  parameter logic [W-1:0] FIXED_SEED = '1,
  parameter logic [W-1:0] TAP_MASK = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         hdr_done,
  input  logic [1:0]   mode_sel,
  input  logic         seed_wr,
  input  logic         seed_wr_idx,
  input  logic [W-1:0] seed_wr_data,
  input  logic         in_valid,
  input  logic         in_bit,
  output logic         out_valid,
  output logic         out_bit
);
  localparam logic [1:0] MODE_OFF = 2'd3;

  logic [W-1:0] seed1_q, seed2_q, state_q, pick;
  logic [1:0]   mode_q;
  logic         payload_q;

  always_comb begin
    case (mode_sel)
      2'd0:    pick = FIXED_SEED;
      2'd1:    pick = seed1_q;
      2'd2:    pick = seed2_q;
      default: pick = '0;
    endcase
  end

  wire in_hdr = !payload_q || hdr_done || frame_start;
  wire ks = !in_hdr && (mode_q != MODE_OFF) && state_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed1_q <= '0;
      seed2_q <= '0;
    end else if (seed_wr) begin
      if (seed_wr_idx) seed2_q <= seed_wr_data;
      else             seed1_q <= seed_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      mode_q    <= MODE_OFF;
      payload_q <= 1'b0;
    end else if (hdr_done) begin
      state_q   <= pick;
      mode_q    <= mode_sel;
      payload_q <= 1'b1;
    end else if (frame_start) begin
      payload_q <= 1'b0;
    end else if (in_valid && payload_q) begin
      state_q <= {state_q[W-2:0], ^(state_q & TAP_MASK)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_bit   <= in_valid && (in_bit ^ ks);
    end
  end
endmodule

module seed_scrambler_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_start,
  input logic         hdr_done,
  input logic         in_valid,
  input logic         in_bit,
  input logic         out_valid,
  input logic         out_bit,
  input logic         payload_q,
  input logic [1:0]   mode_q,
  input logic [W-1:0] state_q
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_bit));
  assert_header_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!payload_q || hdr_done || frame_start)) |=> (out_bit == $past(in_bit)));
  assert_gap_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !hdr_done) |=> $stable(state_q));
  assert_off_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_q == 2'd3) |=> (out_bit == $past(in_bit)));
  assert_zero_stuck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !hdr_done) |=> (state_q == '0));
endmodule

bind seed_scrambler seed_scrambler_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hdr_done(hdr_done),
  .in_valid(in_valid), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
  .payload_q(payload_q), .mode_q(mode_q), .state_q(state_q)
);

// File: tb/seed_scrambler_tb.sv
`timescale 1ns/1ps
module seed_scrambler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, hdr_done = 0, seed_wr = 0, seed_wr_idx = 0, in_valid = 0, in_bit = 0;
  logic [1:0] mode_sel = 0;
  logic [15:0] seed_wr_data = 0;
  logic out_valid, out_bit, rx_valid, rx_bit;
  logic fs_d = 0, hd_d = 0;

  always #2.5 clk = ~clk;

  seed_scrambler dut_i (.clk, .rst_n, .frame_start, .hdr_done, .mode_sel, .seed_wr,
    .seed_wr_idx, .seed_wr_data, .in_valid, .in_bit, .out_valid, .out_bit);

  seed_scrambler rx_i (.clk, .rst_n, .frame_start(fs_d), .hdr_done(hd_d), .mode_sel,
    .seed_wr, .seed_wr_idx, .seed_wr_data, .in_valid(out_valid), .in_bit(out_bit),
    .out_valid(rx_valid), .out_bit(rx_bit));

  always @(posedge clk) begin
    fs_d <= frame_start;
    hd_d <= hdr_done;
  end

  int checks = 0, errors = 0;
  logic [15:0] m_s1 = 0, m_s2 = 0, m_state = 0;
  logic [1:0]  m_mode = 3;
  logic        m_pay = 0, prev_v = 0, prev_b = 0;

  function automatic logic [15:0] adv(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic b, input logic fs,
                      input logic hd, input logic wr = 0, input logic widx = 0,
                      input logic [15:0] wdata = 0);
    logic exp, hdr;
    @(negedge clk);
    in_valid = v; in_bit = b; frame_start = fs; hdr_done = hd;
    seed_wr = wr; seed_wr_idx = widx; seed_wr_data = wdata;
    hdr = !m_pay || hd || fs;
    exp = v && (b ^ (!hdr && m_mode != 2'd3 && m_state[15]));
    if (hd) begin
      m_state = (mode_sel == 0) ? 16'hFFFF : (mode_sel == 1) ? m_s1 : (mode_sel == 2) ? m_s2 : 16'h0;
      m_mode = mode_sel; m_pay = 1;
    end else if (fs) m_pay = 0;
    else if (v && m_pay) m_state = adv(m_state);
    if (wr) begin
      if (widx) m_s2 = wdata; else m_s1 = wdata;
    end
    @(posedge clk); #1;
    chk("R2 out_valid", out_valid, v);
    chk(hdr ? "R3 header" : tag, out_bit, exp);
    if (prev_v) chk("R9 round trip", rx_bit, prev_b);
    prev_v = v; prev_b = b;
  endtask

  task automatic frame(input string tag, input int md, input int nhdr, input int npay,
                       input int f, input int gap, input bit mutate = 0);
    mode_sel = md[1:0];
    step("R3", 1, f[0], 1, 0);
    for (int i = 1; i < nhdr - 1; i++) step("R3", 1, i[0] ^ f[1], 0, 0);
    step("R3", 1, ~f[0], 0, 1);
    for (int i = 0; i < npay; i++) begin
      int p = (i * 13 + f * 7) ^ (i >> 3) ^ (f >> 2);
      if (mutate && i == 10) begin
        mode_sel = 2'd3;
        step("R7 seed write mid frame", 0, 0, 0, 0, 1, 0, 16'h5A5A);
        step("R7 seed write mid frame", 0, 0, 0, 0, 1, 1, 16'h0F0F);
      end
      if (gap > 0 && i % gap == gap - 1) step(tag, 0, 0, 0, 0);
      step(tag, 1, p[0], 0, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset bit", out_bit, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid held", out_valid, 0);
    chk("R1 reset bit held", out_bit, 0);
    @(negedge clk) rst_n = 1;
    frame("R5 seed1 reset zero R1", 1, 6, 24, 3, 0);
    frame("R4 fixed seed", 0, 8, 60, 1, 5);
    step("R6", 0, 0, 0, 0, 1, 0, 16'hACE1);
    step("R6", 0, 0, 0, 0, 1, 1, 16'h1234);
    frame("R6 seed1", 1, 8, 50, 2, 7);
    frame("R6 seed2", 2, 5, 50, 4, 3);
    frame("R5 off mode", 3, 4, 40, 5, 0);
    step("R8", 0, 0, 0, 0, 1, 1, 16'h0000);
    frame("R8 zero seed", 2, 6, 40, 6, 4);
    frame("R7 latched seed", 1, 6, 40, 7, 0, 1);
    frame("R6 after rewrite", 1, 6, 30, 8, 6);
    for (int s = 0; s < 16; s++) begin
      step("R6", 0, 0, 0, 0, 1, s[0], 16'h1 << s);
      frame("R4 sweep", 1 + s % 2, 3 + s % 4, 33, 9 + s, s % 5);
      frame("R5 sweep", s % 4, 4, 20, s, 0);
    end
    step("R2 idle", 0, 0, 0, 0);
    step("R2 idle", 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule